// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in memory. It takes a 32-bit virtual address and splits it into three fields. From the most significant bit down they are a 12-bit first-level index, a 10-bit second-level index and a 10-bit byte offset within a 1 KB page. The walker reads one first-level entry, whose address comes from a table base input. If that entry is valid, it reads one second-level entry from the table the first entry names. It then reports either a translation for the TLB to store or a page fault.

Both reads go out as word reads on a plain request/acknowledge plus read-data-valid memory port, and memory may take any number of cycles to respond. Every table entry is 32 bits wide. Bit 0 is the valid flag and bit 1 is the write-permission flag. Bits 31:10 hold the page number, which is either the next table's base divided by 1024 or the physical frame. A valid entry with bit 1 clear is read-only. The walker takes one walk at a time. While it is busy, new walk requests are ignored.

Top module: `pt_walker`

## Requirements
- R1: After reset, `walk_ready` is 1 and `mem_req`, `fill_valid` and `fault_valid` are 0.
- R2: The first read goes to address `table_base + vaddr[31:20]*4`, where `table_base` is sampled when the walk is accepted.
- R3: The second read goes to address `{first_entry[31:10], 10'b0} + vaddr[19:10]*4`.
- R4: Once `mem_req` is asserted, it stays high with an unchanged `mem_addr` until a cycle in which `mem_ack` is 1, however many cycles that takes. Read data is taken on the first `mem_rvalid` after the acknowledge.
- R5: If the first entry has bit 0 clear, `fault_valid` pulses for one cycle with `fault_inner`=0, and no second read is issued.
- R6: If the first entry is valid and the second entry has bit 0 clear, `fault_valid` pulses for one cycle with `fault_inner`=1.
- R7: If both entries are valid, `fill_valid` pulses for one cycle. During that pulse `fill_frame` is `second_entry[31:10]` and `fill_paddr` is `{fill_frame, vaddr[9:0]}`.
- R8: During a fill, `fill_writable` is the AND of bit 1 of both entries.
- R9: A walk starts only when `walk_req` is high while `walk_ready` is 1. Requests made during a walk are dropped, so they cause no memory read and do not change the result.
- R10: `fill_valid` and `fault_valid` are never high together, and `walk_ready` returns to 1 in the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_req | input | 1 | Start a walk (taken only while ready) |
| walk_vaddr | input | 32 | Virtual address to translate |
| table_base | input | 32 | Byte address of the first-level table |
| walk_ready | output | 1 | Idle and able to accept a walk |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Request accepted by memory |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| fill_valid | output | 1 | One-cycle translation result |
| fill_frame | output | 22 | Physical frame number |
| fill_writable | output | 1 | Page may be written |
| fill_paddr | output | 32 | Translated physical address |
| fault_valid | output | 1 | One-cycle page fault |
| fault_inner | output | 1 | 0: first-level entry invalid, 1: second-level entry invalid |

## Verification
Two conditions are the hardest to create from the ports. One is a walk request that arrives while a walk is already in progress. The other is a request held for several cycles before memory acknowledges it. The bench runs hundreds of walks over a computed table image in which valid and writable flags vary with the entry address. For each walk it varies both the acknowledge delay and the data delay. On every tenth walk it injects a second request with a different address while the first read is pending. It then checks that the result still belongs to the first address and that no extra read follows.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW    = 32,
  parameter int OUT_W = 12,
  parameter int IN_W  = 10,
  parameter int OFF_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                walk_req,
  input  logic [AW-1:0]       walk_vaddr,
  input  logic [AW-1:0]       table_base,
  output logic                walk_ready,
  output logic                mem_req,
  output logic [AW-1:0]       mem_addr,
  input  logic                mem_ack,
  input  logic                mem_rvalid,
  input  logic [AW-1:0]       mem_rdata,
  output logic                fill_valid,
  output logic [AW-OFF_W-1:0] fill_frame,
  output logic                fill_writable,
  output logic [AW-1:0]       fill_paddr,
  output logic                fault_valid,
  output logic                fault_inner
);
  localparam int PN_W   = AW - OFF_W;
  localparam int OUT_LO = IN_W + OFF_W;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_OUT, S_WT_OUT, S_RD_IN, S_WT_IN, S_DONE, S_FAULT
  } walk_st_t;

  walk_st_t      st;
  logic [AW-1:0] va_q, base_q, out_q, in_q;
  logic          lvl_q;

  logic [AW-1:0] out_ofs, in_ofs, in_base;
  assign out_ofs = AW'({va_q[AW-1:OUT_LO], 2'b00});
  assign in_ofs  = AW'({va_q[OUT_LO-1:OFF_W], 2'b00});
  assign in_base = {out_q[AW-1:OFF_W], {OFF_W{1'b0}}};

  assign walk_ready    = (st == S_IDLE);
  assign mem_req       = (st == S_RD_OUT) || (st == S_RD_IN);
  assign mem_addr      = (st == S_RD_IN) ? in_base + in_ofs : base_q + out_ofs;
  assign fill_valid    = (st == S_DONE);
  assign fill_frame    = in_q[AW-1:OFF_W];
  assign fill_writable = out_q[1] & in_q[1];
  assign fill_paddr    = {in_q[AW-1:OFF_W], va_q[OFF_W-1:0]};
  assign fault_valid   = (st == S_FAULT);
  assign fault_inner   = lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va_q   <= '0;
      base_q <= '0;
      out_q  <= '0;
      in_q   <= '0;
      lvl_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (walk_req) begin
          va_q   <= walk_vaddr;
          base_q <= table_base;
          st     <= S_RD_OUT;
        end
        S_RD_OUT: if (mem_ack) st <= S_WT_OUT;
        S_WT_OUT: if (mem_rvalid) begin
          out_q <= mem_rdata;
          if (mem_rdata[0]) st <= S_RD_IN;
          else begin
            lvl_q <= 1'b0;
            st    <= S_FAULT;
          end
        end
        S_RD_IN: if (mem_ack) st <= S_WT_IN;
        S_WT_IN: if (mem_rvalid) begin
          in_q <= mem_rdata;
          if (mem_rdata[0]) st <= S_DONE;
          else begin
            lvl_q <= 1'b1;
            st    <= S_FAULT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  a_r9_ready_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ready |-> !mem_req);
  a_r9_start: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ready && walk_req |=> mem_req);
  a_r7_fill_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $past(mem_rvalid) && $past(mem_rdata[0]));
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fault_valid));
  a_r10_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid || fault_valid |=> walk_ready);
  a_r5_no_inner_read: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !fault_inner |=> !mem_req);
endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_req = 1'b0;
  logic [31:0] walk_vaddr = '0;
  logic [31:0] table_base = '0;
  logic        walk_ready, mem_req, mem_ack = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        fill_valid, fill_writable, fault_valid, fault_inner;
  logic [21:0] fill_frame;
  logic [31:0] fill_paddr;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .walk_req(walk_req), .walk_vaddr(walk_vaddr),
    .table_base(table_base), .walk_ready(walk_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .fill_valid(fill_valid), .fill_frame(fill_frame),
    .fill_writable(fill_writable), .fill_paddr(fill_paddr),
    .fault_valid(fault_valid), .fault_inner(fault_inner));

  function automatic logic [31:0] mw(input logic [31:0] a);
    logic [21:0] h;
    logic v;
    h = a[23:2] ^ 22'h15A5A;
    v = (a[6:2] % 5) != 0;
    return {h, 8'h00, a[3], v};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic serve(input string req, input logic [31:0] ea, input int lat, input int lat2);
    int n = 0;
    while (!mem_req && n < 20) begin @(negedge clk); n++; end
    chk({req, " request seen"}, 32'(mem_req), 32'd1);
    chk({req, " address"}, mem_addr, ea);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk("R4 request held", {31'd0, mem_req}, 32'd1);
      chk("R4 address stable", mem_addr, ea);
    end
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    for (int k = 0; k < lat2; k++) @(negedge clk);
    mem_rvalid = 1'b1;
    mem_rdata  = mw(ea);
    @(negedge clk);
    mem_rvalid = 1'b0;
    mem_rdata  = 32'hDEAD_BEEF;
  endtask

  task automatic do_walk(input logic [31:0] va, input logic [31:0] tb,
                         input int lat, input int lat2, input bit inject);
    logic [31:0] oa, oe, ia, ie;
    oa = tb + {18'd0, va[31:20], 2'b00};
    oe = mw(oa);
    ia = {oe[31:10], 10'd0} + {20'd0, va[19:10], 2'b00};
    ie = mw(ia);
    @(negedge clk);
    walk_req = 1'b1; walk_vaddr = va; table_base = tb;
    @(negedge clk);
    walk_req = 1'b0;
    if (inject) begin
      walk_req = 1'b1; walk_vaddr = ~va; table_base = tb ^ 32'h0010_0000;
    end
    serve("R2", oa, lat, lat2);
    walk_req = 1'b0;
    if (!oe[0]) begin
      chk("R5 fault", {30'd0, fault_valid, fault_inner}, 32'd2);
      chk("R10 no fill", {31'd0, fill_valid}, 32'd0);
      chk("R5 no inner read", {31'd0, mem_req}, 32'd0);
    end else begin
      serve("R3", ia, lat2, lat);
      if (!ie[0]) begin
        chk("R6 fault", {30'd0, fault_valid, fault_inner}, 32'd3);
        chk("R10 no fill", {31'd0, fill_valid}, 32'd0);
      end else begin
        chk("R7 fill", {31'd0, fill_valid}, 32'd1);
        chk("R10 no fault", {31'd0, fault_valid}, 32'd0);
        chk("R7 frame", {10'd0, fill_frame}, {10'd0, ie[31:10]});
        chk("R7 paddr", fill_paddr, {ie[31:10], va[9:0]});
        chk("R8 writable", {31'd0, fill_writable}, {31'd0, oe[1] & ie[1]});
      end
    end
    @(negedge clk);
    chk("R10 back to ready", {31'd0, walk_ready}, 32'd1);
    chk("R10 pulse ended", {30'd0, fill_valid, fault_valid}, 32'd0);
    if (inject) begin
      @(negedge clk);
      chk("R9 dropped request caused no read", {31'd0, mem_req}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", {31'd0, walk_ready}, 32'd1);
    chk("R1 outputs idle", {29'd0, mem_req, fill_valid, fault_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {30'd0, walk_ready, mem_req}, 32'd2);
    for (int i = 0; i < 640; i++) begin
      logic [31:0] va, tb;
      va = {12'((i * 37) % 4096), 10'((i * 53) % 1024), 10'((i * 11) % 1024)};
      tb = (i % 2) ? 32'h0123_4000 : 32'h0004_0000;
      do_walk(va, tb, i % 4, (i / 4) % 3, (i % 10) == 3);
    end
    do_walk(32'hFFFF_FFFF, 32'h0004_0000, 5, 0, 1'b1);
    do_walk(32'h0000_0000, 32'h0004_0000, 0, 5, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule